// File: doc/BRIEF.md
# Stream last-beat and byte-enable marker

This block sits in a packet stream of `DW`-bit beats that carries the packet's byte length on every beat. It decides which beat ends the packet and which byte lane on that beat holds the final valid byte. It sends every beat out one clock later through a single output register stage.

When the upstream side ends a packet itself, with an end flag and a non-zero lane mask, the block passes both on unchanged. Otherwise it keeps a running byte total for the current packet. The total starts at one full beat's worth of bytes and rises by that amount on each accepted beat. The first beat whose total reaches or passes the length ends the packet, and the lane mask is looked up from the length remainder. The total is never subtracted from the length, so a tiny or zero length cannot wrap the arithmetic.

The output register loads only on beats where the input is valid. When the input goes idle, even right after an end beat, the last data, end flag and mask stay as they were.

Top module: `lbe_gen`

## Requirements
- R1: While `rst_n` is low and right after it, `m_valid`, `m_last`, `m_last_be` and `m_data` are all zero.
- R2: `m_valid` equals the value `s_valid` had one clock earlier.
- R3: `m_data`, `m_last` and `m_last_be` load from the input only on a clock where `s_valid` is high. On any other clock they keep their value.
- R4: The running total starts at `DW/8` at reset and at the start of each packet, and grows by `DW/8` on each accepted beat. A beat is marked final by the block when its total is greater than or equal to `s_length`.
- R5: For a length that is not a multiple of `DW/8`, the final beat is beat number ceil(length/(DW/8)). No earlier beat is marked final.
- R6: On a final beat that the block computes, `m_last_be` has exactly one bit set. With r = length mod (DW/8), that bit is bit r-1, or bit `DW/8`-1 when r is 0 (bit 0 is the first byte lane).
- R7: On any output beat with `m_last` low, `m_last_be` is zero. This holds even when the input mask was non-zero on that beat.
- R8: An input beat with `s_last` high and a non-zero `s_last_be` comes out with `m_last` high and `m_last_be` equal to `s_last_be`.
- R9: An input beat with `s_last` high and a zero `s_last_be` comes out final, with the mask computed from the length as in R6.
- R10: After any beat that goes out final, the running total restarts at `DW/8` for the next beat.
- R11: A length from 0 up to `DW/8` ends the packet on its first beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input beat present |
| s_data | input | DW | Input beat data |
| s_last | input | 1 | Upstream end-of-packet flag |
| s_last_be | input | DW/8 | Upstream final-lane mask (zero when not supplied) |
| s_length | input | LEN_W | Packet byte length, held for the whole packet |
| m_valid | output | 1 | Output beat present |
| m_data | output | DW | Delayed beat data |
| m_last | output | 1 | End-of-packet flag |
| m_last_be | output | DW/8 | One-hot final byte lane, zero on other beats |

## Verification
The bench builds the block with `DW` = 32 and `LEN_W` = 8. The four-lane beat makes every remainder from 0 to 3 reachable with lengths of a few bytes, so every mask value and the zero-length and single-beat cases appear in a short vector table. The 8-bit length lets a 255-byte packet run to its 64th beat. That pushes the running total past the largest length the field can hold, which shows the total's extra bit is needed.

// File: rtl/lbe_pkg.sv
package lbe_pkg;

  // Index of the byte lane that holds the final byte of a packet.
  function automatic int unsigned final_lane(int unsigned nbytes, int unsigned len);
    int unsigned rem;
    rem = len % nbytes;
    return (rem == 0) ? nbytes - 1 : rem - 1;
  endfunction

  // True once the bytes covered so far reach the packet length.
  function automatic bit covered(int unsigned total, int unsigned len);
    return total >= len;
  endfunction

endpackage

// File: rtl/lbe_count.sv
module lbe_count #(
  parameter int unsigned BYTES = 8,
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_ok,
  input  logic             pkt_end,
  input  logic [LEN_W-1:0] len,
  output logic             hit
);
  import lbe_pkg::*;

  localparam int unsigned CW = LEN_W + 1;
  localparam logic [CW-1:0] STEP = CW'(BYTES);

  logic [CW-1:0] total;

  always_ff @(posedge clk) begin
    if (!rst_n)
      total <= STEP;
    else if (beat_ok)
      total <= pkt_end ? STEP : total + STEP;
  end

  assign hit = covered(int'(total), int'(len));

  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && pkt_end) |=> (total == STEP));

  a_r4_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    total != '0);

endmodule

// File: rtl/lbe_pick.sv
module lbe_pick #(
  parameter int unsigned BYTES = 8,
  parameter int unsigned LEN_W = 16
) (
  input  logic             in_last,
  input  logic [BYTES-1:0] in_be,
  input  logic [LEN_W-1:0] len,
  input  logic             hit,
  output logic             given,
  output logic             out_last,
  output logic [BYTES-1:0] out_be
);
  import lbe_pkg::*;

  logic [BYTES-1:0] calc_be;

  assign given = in_last && (in_be != '0);
  assign calc_be = BYTES'(1) << final_lane(BYTES, int'(len));

  always_comb begin
    if (given) begin
      out_last = 1'b1;
      out_be   = in_be;
    end else begin
      out_last = in_last || hit;
      out_be   = (in_last || hit) ? calc_be : '0;
    end
  end

endmodule

// File: rtl/lbe_stage.sv
module lbe_stage #(
  parameter int unsigned DW    = 64,
  parameter int unsigned BYTES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic             in_last,
  input  logic [BYTES-1:0] in_be,
  output logic             q_valid,
  output logic [DW-1:0]    q_data,
  output logic             q_last,
  output logic [BYTES-1:0] q_be
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_last  <= 1'b0;
      q_be    <= '0;
    end else begin
      q_valid <= in_valid;
      if (in_valid) begin
        q_data <= in_data;
        q_last <= in_last;
        q_be   <= in_be;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> q_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !q_valid);

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(q_data) && $stable(q_last) && $stable(q_be)));

endmodule

// File: rtl/lbe_gen.sv
module lbe_gen #(
  parameter int unsigned DW    = 64,
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [DW-1:0]     s_data,
  input  logic              s_last,
  input  logic [DW/8-1:0]   s_last_be,
  input  logic [LEN_W-1:0]  s_length,
  output logic              m_valid,
  output logic [DW-1:0]     m_data,
  output logic              m_last,
  output logic [DW/8-1:0]   m_last_be
);

  localparam int unsigned BYTES = DW / 8;

  // Internal events, named for the assertions below.
  logic             ev_hit;
  logic             ev_given;
  logic             ev_end;
  logic [BYTES-1:0] ev_be;

  lbe_count #(.BYTES(BYTES), .LEN_W(LEN_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat_ok (s_valid),
    .pkt_end (ev_end),
    .len     (s_length),
    .hit     (ev_hit)
  );

  lbe_pick #(.BYTES(BYTES), .LEN_W(LEN_W)) u_pick (
    .in_last  (s_last),
    .in_be    (s_last_be),
    .len      (s_length),
    .hit      (ev_hit),
    .given    (ev_given),
    .out_last (ev_end),
    .out_be   (ev_be)
  );

  lbe_stage #(.DW(DW), .BYTES(BYTES)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (s_valid),
    .in_data  (s_data),
    .in_last  (ev_end),
    .in_be    (ev_be),
    .q_valid  (m_valid),
    .q_data   (m_data),
    .q_last   (m_last),
    .q_be     (m_last_be)
  );

  a_r8_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && ev_given) |=> (m_last && (m_last_be == $past(s_last_be))));

  a_r7_mask_only_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_last) |-> (m_last_be == '0));

  a_r6_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && ev_end && !ev_given) |=> $onehot(m_last_be));

endmodule

// File: tb/test_lbe_gen.sv
module test_lbe_gen;
  localparam int DW    = 32;
  localparam int LEN_W = 8;
  localparam int NB    = DW / 8;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic          v;
    logic          l;
    logic [NB-1:0] be;
    logic [7:0]    len;
    logic          xl;
    logic [NB-1:0] xbe;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 4'b0000, 8'd10, 1'b0, 4'b0000}, // R4 beat 1 of 10 bytes
    '{1'b1, 1'b0, 4'b0000, 8'd10, 1'b0, 4'b0000}, // R5 not yet
    '{1'b0, 1'b0, 4'b0000, 8'd10, 1'b0, 4'b0000}, // R3 idle
    '{1'b1, 1'b0, 4'b0000, 8'd10, 1'b1, 4'b0010}, // R5 R6 rem 2
    '{1'b1, 1'b0, 4'b0000, 8'd3,  1'b1, 4'b0100}, // R11 rem 3
    '{1'b1, 1'b0, 4'b0000, 8'd0,  1'b1, 4'b1000}, // R11 zero length
    '{1'b1, 1'b0, 4'b0000, 8'd8,  1'b0, 4'b0000}, // R4 aligned
    '{1'b1, 1'b0, 4'b0000, 8'd8,  1'b1, 4'b1000}, // R6 rem 0
    '{1'b1, 1'b1, 4'b0011, 8'd20, 1'b1, 4'b0011}, // R8 pass through
    '{1'b1, 1'b0, 4'b0000, 8'd20, 1'b0, 4'b0000}, // R10 restart
    '{1'b1, 1'b1, 4'b0000, 8'd20, 1'b1, 4'b1000}, // R9 forced end
    '{1'b1, 1'b0, 4'b0000, 8'd5,  1'b0, 4'b0000}, // R10 restart
    '{1'b0, 1'b0, 4'b0000, 8'd5,  1'b0, 4'b0000}, // R3 idle
    '{1'b0, 1'b0, 4'b0000, 8'd5,  1'b0, 4'b0000}, // R3 idle
    '{1'b1, 1'b0, 4'b0000, 8'd5,  1'b1, 4'b0001}, // R6 rem 1
    '{1'b1, 1'b0, 4'b0000, 8'd4,  1'b1, 4'b1000}, // R11 one full beat
    '{1'b1, 1'b0, 4'b1111, 8'd9,  1'b0, 4'b0000}, // R7 mask ignored
    '{1'b1, 1'b0, 4'b0000, 8'd9,  1'b0, 4'b0000}, // R5
    '{1'b1, 1'b0, 4'b0000, 8'd9,  1'b1, 4'b0001}  // R5 R6
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              s_valid = 1'b0;
  logic [DW-1:0]     s_data = '0;
  logic              s_last = 1'b0;
  logic [NB-1:0]     s_last_be = '0;
  logic [LEN_W-1:0]  s_length = '0;
  logic              m_valid;
  logic [DW-1:0]     m_data;
  logic              m_last;
  logic [NB-1:0]     m_last_be;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  lbe_gen #(.DW(DW), .LEN_W(LEN_W)) i_lbe_gen (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .s_last(s_last), .s_last_be(s_last_be), .s_length(s_length),
    .m_valid(m_valid), .m_data(m_data), .m_last(m_last), .m_last_be(m_last_be)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic l, input logic [NB-1:0] be,
                       input logic [7:0] len, input logic [DW-1:0] d);
    s_valid = v; s_last = l; s_last_be = be; s_length = len; s_data = d;
  endtask

  initial begin
    logic [DW-1:0] hold_d;
    logic          hold_l;
    logic [NB-1:0] hold_be;
    hold_d = '0; hold_l = 1'b0; hold_be = '0;

    repeat (3) @(negedge clk);
    check("R1 valid", 64'(m_valid), 0);
    check("R1 data", 64'(m_data), 0);
    check("R1 last", 64'(m_last), 0);
    check("R1 be", 64'(m_last_be), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].v, VECS[i].l, VECS[i].be, VECS[i].len, DW'(32'h100 + i));
      @(negedge clk);
      check($sformatf("R2 valid row %0d", i), 64'(m_valid), 64'(VECS[i].v));
      if (VECS[i].v) begin
        hold_d = DW'(32'h100 + i); hold_l = VECS[i].xl; hold_be = VECS[i].xbe;
      end
      check($sformatf("R3 data row %0d", i), 64'(m_data), 64'(hold_d));
      check($sformatf("R4 R5 R8 R9 last row %0d", i), 64'(m_last), 64'(hold_l));
      check($sformatf("R6 R7 be row %0d", i), 64'(m_last_be), 64'(hold_be));
    end

    // R5: 255-byte packet ends on beat 64 with lane 2
    for (int b = 1; b <= 64; b++) begin
      drive(1'b1, 1'b0, '0, 8'd255, DW'(b));
      @(negedge clk);
      if (b == 63) check("R5 long beat 63 last", 64'(m_last), 0);
      if (b == 64) begin
        check("R5 long beat 64 last", 64'(m_last), 1);
        check("R6 long beat 64 be", 64'(m_last_be), 64'(4'b0100));
      end
    end

    // R1/R10: reset mid-packet, then total restarts
    drive(1'b1, 1'b0, '0, 8'd8, 32'hA5);
    @(negedge clk);
    rst_n = 1'b0;
    drive(1'b0, 1'b0, '0, 8'd8, '0);
    @(negedge clk);
    check("R1 rerst valid", 64'(m_valid), 0);
    check("R1 rerst data", 64'(m_data), 0);
    check("R1 rerst last", 64'(m_last), 0);
    rst_n = 1'b1;
    drive(1'b1, 1'b0, '0, 8'd8, 32'h5A);
    @(negedge clk);
    check("R10 after reset not last", 64'(m_last), 0);
    drive(1'b0, 1'b0, '0, 8'd8, '0);
    @(negedge clk);
    check("R3 idle after end keeps data", 64'(m_data), 64'(32'h5A));

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule